// File: doc/BRIEF.md
# Packet Timestamp Capture Buffer

This block holds the departure or arrival time of a timing-protocol event packet. Each traffic path, receive and transmit, has its own one-entry capture slot. When the packet classifier upstream pulses that path's event strobe, the slot takes three things in the same clock edge: the free-running 64-bit time value, the packet's 16-bit sequence id, and a valid flag.

Once the flag is set, the slot is locked. Later strobes are dropped and the held values stay as they are. Software reads the time as two 32-bit words, low half and high half, taken from one sampled instant. It then writes a word with bit 16 set to the slot's status register. That write clears the flag and re-arms the slot. Software also makes this write when it enables the feature or changes the packet filters, so that any stale capture is thrown away.

The register port is a flat word address. The upper bits pick the path and the two lowest bits pick the word. Reads are combinational from the held state.

Top module: `ts_capture_buf`

## Requirements
- R1: After synchronous reset every slot is empty, and all readable words of all paths read zero.
- R2: A strobe on an empty slot sets its valid flag at the next clock edge. In that same edge it latches the time value and the sequence id present with the strobe.
- R3: The low word (word select 1) returns time bits 31:0 and the high word (word select 2) returns time bits 63:32. Both come from the single sampled time.
- R4: While a slot's valid flag is set and no clear is written, strobes on that path are ignored. The held time, sequence id and flag stay unchanged.
- R5: Writing a word with bit 16 set to a path's status word (word select 0) clears that path's valid flag at the next edge. After that, the next strobe is captured again.
- R6: These writes have no effect: a status write with bit 16 zero, and any write to the low, high or reserved word.
- R7: A strobe in the same cycle as a clearing status write is captured. The flag stays set and the new time and sequence id are held.
- R8: Paths are independent. A strobe or a clear on one path leaves every other path's state unchanged.
- R9: Address = {path, word select[1:0]}. The status word holds the sequence id in bits 15:0 and the valid flag in bit 16, and reads zero in bits 31:17. Word select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_in | input | 64 | Current free-running time value |
| evt_strobe | input | NUM_PATHS | One-cycle event pulse per path |
| evt_seq | input | NUM_PATHS*16 | Sequence id per path, path p in bits [16p+15:16p] |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | PATH_W+2 | Register word address {path, word select} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The bench builds the block with two paths, a 64-bit time and 16-bit sequence ids. With these values the top address bit selects the path, so cross-path leakage of a strobe or a clear shows up directly. The bench changes the low and high halves of the time input every cycle with different formulas. A high word taken from another sample than the low word therefore shows up against the model. The same-cycle clear-and-strobe case and the ignored-write cases are driven on one path while the other path holds a capture.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

    parameter int WORD_W    = 32;
    parameter int SEQ_W     = 16;
    parameter int TIME_W    = 2 * WORD_W;
    parameter int VALID_BIT = SEQ_W;
    parameter int SEL_W     = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_LOW    = 2'd1,
        SEL_HIGH   = 2'd2,
        SEL_RSVD   = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic              valid;
        logic [SEQ_W-1:0]  seq;
        logic [TIME_W-1:0] stamp;
    } cap_entry_t;

    function automatic logic [WORD_W-1:0] status_word(input cap_entry_t e);
        logic [WORD_W-1:0] w;
        w                 = '0;
        w[SEQ_W-1:0]      = e.seq;
        w[VALID_BIT]      = e.valid;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] stamp_word(input logic [TIME_W-1:0] t,
                                                     input int idx);
        return t[idx*WORD_W +: WORD_W];
    endfunction

endpackage

// File: rtl/ts_cap_decode.sv
module ts_cap_decode
    import ts_cap_pkg::*;
#(
    parameter int NUM_PATHS = 2,
    parameter int PATH_W    = 1,
    localparam int ADDR_W   = PATH_W + SEL_W
) (
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [PATH_W-1:0]    path_idx,
    output word_sel_e            word_sel,
    output logic [NUM_PATHS-1:0] clr_req
);

    logic clear_bit;
    logic unused_wdata;

    assign path_idx     = reg_addr[ADDR_W-1:SEL_W];
    assign word_sel     = word_sel_e'(reg_addr[SEL_W-1:0]);
    assign clear_bit    = reg_wdata[VALID_BIT];
    assign unused_wdata = ^{reg_wdata[WORD_W-1:VALID_BIT+1], reg_wdata[VALID_BIT-1:0]};

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_clr
        assign clr_req[p] = reg_wr && clear_bit && (word_sel == SEL_STATUS)
                            && (int'(path_idx) == p);
    end

endmodule

// File: rtl/ts_cap_slot.sv
module ts_cap_slot
    import ts_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] time_in,
    input  logic              strobe,
    input  logic [SEQ_W-1:0]  seq_in,
    input  logic              clr,
    output cap_entry_t        entry_q
);

    logic take;

    // Armed when empty, or when being cleared in this very cycle.
    assign take = strobe && (!entry_q.valid || clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= '0;
        end else if (take) begin
            entry_q.valid <= 1'b1;
            entry_q.seq   <= seq_in;
            entry_q.stamp <= time_in;
        end else if (clr) begin
            entry_q.valid <= 1'b0;
        end
    end

endmodule

// File: rtl/ts_cap_readmux.sv
module ts_cap_readmux
    import ts_cap_pkg::*;
#(
    parameter int NUM_PATHS = 2,
    parameter int PATH_W    = 1
) (
    input  cap_entry_t [NUM_PATHS-1:0] entries,
    input  logic [PATH_W-1:0]          path_idx,
    input  word_sel_e                  word_sel,
    output logic [WORD_W-1:0]          rdata
);

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PATHS; p++) begin
            if (int'(path_idx) == p) begin
                case (word_sel)
                    SEL_STATUS: rdata = status_word(entries[p]);
                    SEL_LOW:    rdata = stamp_word(entries[p].stamp, 0);
                    SEL_HIGH:   rdata = stamp_word(entries[p].stamp, 1);
                    default:    rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ts_capture_buf.sv
module ts_capture_buf
    import ts_cap_pkg::*;
#(
    parameter int NUM_PATHS = 2,
    localparam int PATH_W   = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1,
    localparam int ADDR_W   = PATH_W + SEL_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [TIME_W-1:0]          time_in,
    input  logic [NUM_PATHS-1:0]       evt_strobe,
    input  logic [NUM_PATHS*SEQ_W-1:0] evt_seq,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [WORD_W-1:0]          reg_wdata,
    output logic [WORD_W-1:0]          reg_rdata
);

    logic [PATH_W-1:0]          path_idx;
    word_sel_e                  word_sel;
    logic [NUM_PATHS-1:0]       clr_req;
    cap_entry_t [NUM_PATHS-1:0] cap_q;

    ts_cap_decode #(.NUM_PATHS(NUM_PATHS), .PATH_W(PATH_W)) u_decode (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .path_idx  (path_idx),
        .word_sel  (word_sel),
        .clr_req   (clr_req)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_slot
        ts_cap_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .time_in (time_in),
            .strobe  (evt_strobe[p]),
            .seq_in  (evt_seq[p*SEQ_W +: SEQ_W]),
            .clr     (clr_req[p]),
            .entry_q (cap_q[p])
        );
    end

    ts_cap_readmux #(.NUM_PATHS(NUM_PATHS), .PATH_W(PATH_W)) u_rmux (
        .entries  (cap_q),
        .path_idx (path_idx),
        .word_sel (word_sel),
        .rdata    (reg_rdata)
    );

endmodule

// File: rtl/ts_capture_buf_chk.sv
module ts_capture_buf_chk
    import ts_cap_pkg::*;
#(
    parameter int NUM_PATHS = 2,
    localparam int PATH_W   = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1,
    localparam int ADDR_W   = PATH_W + SEL_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic [TIME_W-1:0]          time_in,
    input logic [NUM_PATHS-1:0]       evt_strobe,
    input logic [NUM_PATHS*SEQ_W-1:0] evt_seq,
    input logic                       reg_wr,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic                       wr_bit,
    input cap_entry_t [NUM_PATHS-1:0] cap_q
);

    logic rst_seen_q;
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        // R1
        if (rst_seen_q && !rst) begin
            reset_empty_chk: assert (cap_q == '0);
        end
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_chk
        logic clr_p;
        assign clr_p = reg_wr && wr_bit && (reg_addr[SEL_W-1:0] == SEL_W'(0))
                       && (int'(reg_addr[ADDR_W-1:SEL_W]) == p);

        // R2
        capture_empty_chk: assert property (@(posedge clk) disable iff (rst)
            (!cap_q[p].valid && evt_strobe[p]) |=>
            (cap_q[p].valid && cap_q[p].stamp == $past(time_in)
             && cap_q[p].seq == $past(evt_seq[p*SEQ_W +: SEQ_W])));

        // R4
        lockout_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (cap_q[p].valid && !clr_p) |=>
            (cap_q[p].valid && $stable(cap_q[p].stamp) && $stable(cap_q[p].seq)));

        // R5
        clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_p && !evt_strobe[p]) |=> !cap_q[p].valid);

        // R7
        clear_capture_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_p && evt_strobe[p]) |=>
            (cap_q[p].valid && cap_q[p].stamp == $past(time_in)));
    end

endmodule

bind ts_capture_buf ts_capture_buf_chk #(.NUM_PATHS(NUM_PATHS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .time_in    (time_in),
    .evt_strobe (evt_strobe),
    .evt_seq    (evt_seq),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .wr_bit     (reg_wdata[ts_cap_pkg::VALID_BIT]),
    .cap_q      (cap_q)
);

// File: tb/ts_capture_buf_test.sv
`timescale 1ns/1ps
module ts_capture_buf_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_in;
    logic [1:0]  evt_strobe = '0;
    logic [31:0] evt_seq = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    logic [31:0] tcount = '0;
    int          n_run = 0;
    int          n_fail = 0;

    logic        m_valid [2];
    logic [15:0] m_seq   [2];
    logic [63:0] m_time  [2];

    always #2.5 clk = ~clk;

    assign time_in = {tcount + 32'h8000_0000, tcount * 32'h0001_0003 ^ 32'h5A5A_0F0F};

    ts_capture_buf #(.NUM_PATHS(2)) uut (
        .clk        (clk),
        .rst        (rst),
        .time_in    (time_in),
        .evt_strobe (evt_strobe),
        .evt_seq    (evt_seq),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    function automatic logic [31:0] model_read(input logic [2:0] a);
        int p = int'(a[2]);
        case (a[1:0])
            2'd0:    return {15'd0, m_valid[p], m_seq[p]};
            2'd1:    return m_time[p][31:0];
            2'd2:    return m_time[p][63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] wd,
                        input logic [1:0] stb, input logic [15:0] s0,
                        input logic [15:0] s1, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        tcount     = tcount + 1;
        reg_wr     = wr;
        reg_addr   = a;
        reg_wdata  = wd;
        evt_strobe = stb;
        evt_seq    = {s1, s0};
        #1;
        exp = model_read(a);
        n_run++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            logic clr;
            clr = wr && wd[16] && a[1:0] == 2'd0 && int'(a[2]) == p;
            if (stb[p] && (!m_valid[p] || clr)) begin
                m_valid[p] = 1'b1;
                m_seq[p]   = (p == 0) ? s0 : s1;
                m_time[p]  = time_in;
            end else if (clr) begin
                m_valid[p] = 1'b0;
            end
        end
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 8; a++) step(1'b0, 3'(a), 32'd0, 2'b00, 16'd0, 16'd0, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            m_valid[p] = 1'b0; m_seq[p] = '0; m_time[p] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sweep("R1 R9 reset state");

        // R2 R3: capture on empty path 0
        step(1'b0, 3'd0, 32'd0, 2'b01, 16'h1234, 16'h0, "R2");
        sweep("R2 R3 captured words");

        // R4: further strobes are dropped while valid
        step(1'b0, 3'd1, 32'd0, 2'b01, 16'h5555, 16'h0, "R4");
        step(1'b0, 3'd2, 32'd0, 2'b01, 16'h6666, 16'h0, "R4");
        sweep("R4 lockout");

        // R6: non-clearing writes
        step(1'b1, 3'd0, 32'hFFFE_FFFF, 2'b00, 16'h0, 16'h0, "R6 status bit16 zero");
        step(1'b1, 3'd1, 32'h0001_0000, 2'b00, 16'h0, 16'h0, "R6 low word");
        step(1'b1, 3'd2, 32'hFFFF_FFFF, 2'b00, 16'h0, 16'h0, "R6 high word");
        step(1'b1, 3'd3, 32'h0001_0000, 2'b00, 16'h0, 16'h0, "R6 reserved word");
        sweep("R6 state kept");

        // R8: path 1 captures while path 0 holds
        step(1'b0, 3'd4, 32'd0, 2'b10, 16'h0, 16'hBEEF, "R8");
        sweep("R8 both held");

        // R5 R8: clear path 1 only
        step(1'b1, 3'd4, 32'h0001_0000, 2'b00, 16'h0, 16'h0, "R5 clear path1");
        sweep("R5 R8 path1 cleared, path0 held");

        // R5: re-arm after clear
        step(1'b0, 3'd5, 32'd0, 2'b10, 16'h0, 16'hC0DE, "R5 rearm");
        sweep("R5 recaptured");

        // R7: clear and strobe in one cycle on path 0
        step(1'b1, 3'd0, 32'h0001_0000, 2'b01, 16'h7777, 16'h0, "R7");
        sweep("R7 new capture held");

        // R7 R8: strobe on path 1 while path 0 clears alone
        step(1'b1, 3'd0, 32'hFFFF_FFFF, 2'b10, 16'h0, 16'h1111, "R7 R8 path1 locked");
        sweep("R8 path0 cleared only");

        // R3: back-to-back capture after clear with changing time
        step(1'b0, 3'd2, 32'd0, 2'b01, 16'hA5A5, 16'h0, "R3");
        step(1'b0, 3'd1, 32'd0, 2'b00, 16'h0, 16'h0, "R3 low");
        step(1'b0, 3'd2, 32'd0, 2'b00, 16'h0, 16'h0, "R3 high");
        sweep("R3 R9 final");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule